// File: doc/BRIEF.md
# Subset Instruction Decoder for 32-bit Power Integer Code

This block decodes one 32-bit instruction word into control fields for a small integer core. It is purely combinational. A byte-order input first puts the word into a canonical order. A primary-opcode table then picks an instruction class, consulting the 10-bit extended field for the two primaries that use one. Finally a routing stage maps the operand fields onto fixed numbered register ports. Those ports are three general-register reads, one general-register write, three condition-register (CR) field reads, one CR field write and a special-register read.

The supported classes are:
- reg-reg and immediate add/and/or;
- indexed and D-form loads and stores of words, halfwords and bytes, with update variants;
- register compare;
- the three word rotates;
- unconditional and conditional branches, including branch to link register and branch to count register;
- CR bit AND.

Every other encoding is flagged illegal. The raw BO, BI, SH, MB, ME and BF fields are passed through untouched for later stages. Immediate formatting and execution belong to other blocks.

Top module: `pwr_subset_decoder`

## Requirements
- R1: With `big_endian_i`=1 the word is taken as given. With 0, the byte at bits [7:0] of `insn_i` is the most significant byte. Every output depends only on the reordered word, so a word and its byte-reversed image with the flag cleared decode identically.
- R2: The operation code output uses these values: 0 none, 1 add, 2 and, 3 or, 4 load, 5 store, 6 compare, 7 rotate, 8 branch, 9 CR logic. For add (primary 31, ext 266), addi (14) and addis (15), RT [25:21] goes to the write port and RA [20:16] goes to read port 1. Add also puts RB [15:11] on read port 2. For and (31/28), or (31/444), andi. (28) and ori (24), RA is written and RS [25:21] goes to read port 3; the reg-reg forms also put RB on read port 2.
- R3: Loads (indexed 31/23; D-form 32, 33, 34, 40) write RT. Stores (indexed 31/151; D-form 36, 37, 38, 44) put RS on read port 3 and write nothing. RA is always on read port 1, and the indexed forms put RB on read port 2. The length output is 4 for word, 2 for halfword and 1 for byte accesses, and 0 for anything that is not a load or store. The update flag is set only for primaries 33 and 37.
- R4: The record flag equals bit 0 for add, and, or and the rotates. It is always 1 for andi. and 0 for every other instruction.
- R5: cmp (31/0) puts RA on read port 1 and RB on read port 2, and writes the CR field numbered by bits [25:23].
- R6: The rotates rlwimi (20), rlwinm (21) and rlwnm (23) put RS on read port 3 and write RA. Only rlwnm puts RB on read port 2.
- R7: Branch forms are b (18), bc (16), bclr (19/16) and bcctr (19/528). They give LK = bit 0, and AA = bit 1 for b and bc (0 for the other two). The special-register select is 1 (link) for bclr, 2 (count) for bcctr and 0 otherwise. bc, bclr and bcctr read the CR field BI[4:2].
- R8: crand (19/257) reads CR fields BA[4:2] on CR port 1 and BB[4:2] on CR port 2. It reads BT[4:2] on CR port 3 and also writes that same field.
- R9: The word 0x60000000 decodes as no operation: code 0, not illegal, no port enabled. Any other ori word decodes as an or.
- R10: Any encoding outside the subset raises `illegal_o`, gives operation code 0, and leaves every enable, flag and length at 0. This includes primaries 30, 58 and 62, whose sub-tables hold nothing in this subset.
- R11: Disabled port selects read 0. BO=[25:21], BI=[20:16], SH=[15:11], MB=[10:6], ME=[5:1] and BF=[25:23] are always output from the reordered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Raw instruction word |
| big_endian_i | input | 1 | 1: word as given; 0: bytes reversed |
| op_o | output | 4 | Internal operation code |
| illegal_o | output | 1 | Encoding outside the subset |
| rd1_en_o | output | 1 | GPR read port 1 used |
| rd1_sel_o | output | 5 | GPR read port 1 register |
| rd2_en_o | output | 1 | GPR read port 2 used |
| rd2_sel_o | output | 5 | GPR read port 2 register |
| rd3_en_o | output | 1 | GPR read port 3 used |
| rd3_sel_o | output | 5 | GPR read port 3 register |
| wr_en_o | output | 1 | GPR write port used |
| wr_sel_o | output | 5 | GPR write register |
| crr1_en_o | output | 1 | CR read port 1 used |
| crr1_sel_o | output | 3 | CR read port 1 field |
| crr2_en_o | output | 1 | CR read port 2 used |
| crr2_sel_o | output | 3 | CR read port 2 field |
| crr3_en_o | output | 1 | CR read port 3 used |
| crr3_sel_o | output | 3 | CR read port 3 field |
| crw_en_o | output | 1 | CR write port used |
| crw_sel_o | output | 3 | CR written field |
| spr_rd_o | output | 2 | Special-register read: 0 none, 1 link, 2 count |
| rc_o | output | 1 | Record flag |
| lk_o | output | 1 | Link flag |
| aa_o | output | 1 | Absolute-address flag |
| upd_o | output | 1 | Base-update flag |
| len_o | output | 3 | Access length in bytes |
| bo_o | output | 5 | Raw BO field |
| bi_o | output | 5 | Raw BI field |
| sh_o | output | 5 | Raw SH field |
| mb_o | output | 5 | Raw MB field |
| me_o | output | 5 | Raw ME field |
| bf_o | output | 3 | Raw BF field |

## Verification
The block holds no state, so a fault shows at the ports in the same cycle the word is presented. A wrong class choice in the opcode table changes the operation code and the whole enable pattern together. A fault in the routing stage moves a register number onto the wrong port, or leaves a port enabled that should be quiet. A fault in the byte-order stage shows only when the reversed image of a word is applied, so every word is applied in both orders and compared field by field.

// File: rtl/pwr_dec_pkg.sv
package pwr_dec_pkg;

  localparam int WORD_W    = 32;
  localparam int GPR_W     = 5;
  localparam int CR_FIELDS = 8;
  localparam int CRF_W     = $clog2(CR_FIELDS);
  localparam int LEN_W     = 3;
  localparam int OP_W      = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 4'd0,
    OP_ADD   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_LOAD  = 4'd4,
    OP_STORE = 4'd5,
    OP_CMP   = 4'd6,
    OP_ROT   = 4'd7,
    OP_BR    = 4'd8,
    OP_CRLOG = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SPR_NONE  = 2'd0,
    SPR_LINK  = 2'd1,
    SPR_COUNT = 2'd2
  } spr_e;

  // instruction classes picked by the opcode tables
  typedef enum logic [4:0] {
    C_ILL, C_NOP, C_ADD, C_ADDI, C_AND, C_OR, C_ANDI, C_ORI,
    C_LDX, C_STX, C_LD, C_ST, C_CMP, C_RLWIMI, C_RLWINM, C_RLWNM,
    C_B, C_BC, C_BCLR, C_BCCTR, C_CRAND
  } cls_e;

  typedef struct packed {
    op_e              op;
    logic             rd1_en;
    logic [GPR_W-1:0] rd1;
    logic             rd2_en;
    logic [GPR_W-1:0] rd2;
    logic             rd3_en;
    logic [GPR_W-1:0] rd3;
    logic             wr_en;
    logic [GPR_W-1:0] wr;
    logic             c1_en;
    logic [CRF_W-1:0] c1;
    logic             c2_en;
    logic [CRF_W-1:0] c2;
    logic             c3_en;
    logic [CRF_W-1:0] c3;
    logic             cw_en;
    logic [CRF_W-1:0] cw;
    spr_e             spr;
    logic             rc;
    logic             lk;
    logic             aa;
    logic             upd;
    logic [LEN_W-1:0] len;
  } route_t;

endpackage

// File: rtl/pwr_byte_order.sv
module pwr_byte_order #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] raw_i,
  input  logic               keep_i,
  output logic [8*BYTES-1:0] word_o
);

  logic [8*BYTES-1:0] reversed;

  for (genvar b = 0; b < BYTES; b++) begin : g_rev
    assign reversed[8*b +: 8] = raw_i[8*(BYTES-1-b) +: 8];
  end

  assign word_o = keep_i ? raw_i : reversed;

endmodule

// File: rtl/pwr_class_table.sv
module pwr_class_table
  import pwr_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output cls_e              cls_o,
  output logic              illegal_o
);

  localparam logic [WORD_W-1:0] NOP_WORD = 32'h6000_0000;

  logic [5:0] prim;
  logic [9:0] ext10;

  assign prim  = word_i[31:26];
  assign ext10 = word_i[10:1];

  always_comb begin
    cls_o = C_ILL;
    case (prim)
      6'd14, 6'd15: cls_o = C_ADDI;
      6'd24:        cls_o = (word_i == NOP_WORD) ? C_NOP : C_ORI;
      6'd28:        cls_o = C_ANDI;
      6'd32, 6'd33, 6'd34, 6'd40: cls_o = C_LD;
      6'd36, 6'd37, 6'd38, 6'd44: cls_o = C_ST;
      6'd20:        cls_o = C_RLWIMI;
      6'd21:        cls_o = C_RLWINM;
      6'd23:        cls_o = C_RLWNM;
      6'd18:        cls_o = C_B;
      6'd16:        cls_o = C_BC;
      6'd31: begin
        case (ext10)
          10'd266: cls_o = C_ADD;
          10'd28:  cls_o = C_AND;
          10'd444: cls_o = C_OR;
          10'd23:  cls_o = C_LDX;
          10'd151: cls_o = C_STX;
          10'd0:   cls_o = C_CMP;
          default: cls_o = C_ILL;
        endcase
      end
      6'd19: begin
        case (ext10)
          10'd16:  cls_o = C_BCLR;
          10'd528: cls_o = C_BCCTR;
          10'd257: cls_o = C_CRAND;
          default: cls_o = C_ILL;
        endcase
      end
      // primaries 30, 58 and 62 own sub-tables with no member in this subset
      default: cls_o = C_ILL;
    endcase
  end

  assign illegal_o = (cls_o == C_ILL);

endmodule

// File: rtl/pwr_operand_route.sv
module pwr_operand_route
  import pwr_dec_pkg::*;
(
  input  cls_e        cls_i,
  input  logic [5:0]  prim_i,
  input  logic [14:0] regf_i,
  input  logic [1:0]  lkaa_i,
  output route_t      rt_o
);

  logic [GPR_W-1:0] f_hi, f_mid, f_lo;
  logic [LEN_W-1:0] mem_len;

  assign f_hi  = regf_i[14:10];
  assign f_mid = regf_i[9:5];
  assign f_lo  = regf_i[4:0];

  always_comb begin
    case (prim_i)
      6'd40, 6'd44: mem_len = LEN_W'(2);
      6'd34, 6'd38: mem_len = LEN_W'(1);
      default:      mem_len = LEN_W'(4);
    endcase
  end

  always_comb begin
    rt_o = '0;
    case (cls_i)
      C_ADD: begin
        rt_o.op = OP_ADD;
        rt_o.wr_en = 1'b1;  rt_o.wr  = f_hi;
        rt_o.rd1_en = 1'b1; rt_o.rd1 = f_mid;
        rt_o.rd2_en = 1'b1; rt_o.rd2 = f_lo;
        rt_o.rc = lkaa_i[0];
      end
      C_ADDI: begin
        rt_o.op = OP_ADD;
        rt_o.wr_en = 1'b1;  rt_o.wr  = f_hi;
        rt_o.rd1_en = 1'b1; rt_o.rd1 = f_mid;
      end
      C_AND, C_OR: begin
        rt_o.op = (cls_i == C_AND) ? OP_AND : OP_OR;
        rt_o.wr_en = 1'b1;  rt_o.wr  = f_mid;
        rt_o.rd3_en = 1'b1; rt_o.rd3 = f_hi;
        rt_o.rd2_en = 1'b1; rt_o.rd2 = f_lo;
        rt_o.rc = lkaa_i[0];
      end
      C_ANDI, C_ORI: begin
        rt_o.op = (cls_i == C_ANDI) ? OP_AND : OP_OR;
        rt_o.wr_en = 1'b1;  rt_o.wr  = f_mid;
        rt_o.rd3_en = 1'b1; rt_o.rd3 = f_hi;
        rt_o.rc = (cls_i == C_ANDI);
      end
      C_LDX, C_LD: begin
        rt_o.op = OP_LOAD;
        rt_o.wr_en = 1'b1;  rt_o.wr  = f_hi;
        rt_o.rd1_en = 1'b1; rt_o.rd1 = f_mid;
        rt_o.rd2_en = (cls_i == C_LDX);
        rt_o.rd2 = (cls_i == C_LDX) ? f_lo : '0;
        rt_o.len = (cls_i == C_LDX) ? LEN_W'(4) : mem_len;
        rt_o.upd = (cls_i == C_LD) && (prim_i == 6'd33);
      end
      C_STX, C_ST: begin
        rt_o.op = OP_STORE;
        rt_o.rd3_en = 1'b1; rt_o.rd3 = f_hi;
        rt_o.rd1_en = 1'b1; rt_o.rd1 = f_mid;
        rt_o.rd2_en = (cls_i == C_STX);
        rt_o.rd2 = (cls_i == C_STX) ? f_lo : '0;
        rt_o.len = (cls_i == C_STX) ? LEN_W'(4) : mem_len;
        rt_o.upd = (cls_i == C_ST) && (prim_i == 6'd37);
      end
      C_CMP: begin
        rt_o.op = OP_CMP;
        rt_o.rd1_en = 1'b1; rt_o.rd1 = f_mid;
        rt_o.rd2_en = 1'b1; rt_o.rd2 = f_lo;
        rt_o.cw_en  = 1'b1; rt_o.cw  = f_hi[4:2];
      end
      C_RLWIMI, C_RLWINM, C_RLWNM: begin
        rt_o.op = OP_ROT;
        rt_o.rd3_en = 1'b1; rt_o.rd3 = f_hi;
        rt_o.wr_en  = 1'b1; rt_o.wr  = f_mid;
        rt_o.rd2_en = (cls_i == C_RLWNM);
        rt_o.rd2 = (cls_i == C_RLWNM) ? f_lo : '0;
        rt_o.rc = lkaa_i[0];
      end
      C_B, C_BC: begin
        rt_o.op = OP_BR;
        rt_o.lk = lkaa_i[0];
        rt_o.aa = lkaa_i[1];
        rt_o.c1_en = (cls_i == C_BC);
        rt_o.c1 = (cls_i == C_BC) ? f_mid[4:2] : '0;
      end
      C_BCLR, C_BCCTR: begin
        rt_o.op = OP_BR;
        rt_o.lk = lkaa_i[0];
        rt_o.spr = (cls_i == C_BCLR) ? SPR_LINK : SPR_COUNT;
        rt_o.c1_en = 1'b1; rt_o.c1 = f_mid[4:2];
      end
      C_CRAND: begin
        rt_o.op = OP_CRLOG;
        rt_o.c1_en = 1'b1; rt_o.c1 = f_mid[4:2];
        rt_o.c2_en = 1'b1; rt_o.c2 = f_lo[4:2];
        rt_o.c3_en = 1'b1; rt_o.c3 = f_hi[4:2];
        rt_o.cw_en = 1'b1; rt_o.cw = f_hi[4:2];
      end
      default: rt_o = '0;
    endcase
  end

endmodule

// File: rtl/pwr_subset_decoder.sv
module pwr_subset_decoder
  import pwr_dec_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        big_endian_i,
  output logic [3:0]  op_o,
  output logic        illegal_o,
  output logic        rd1_en_o,
  output logic [4:0]  rd1_sel_o,
  output logic        rd2_en_o,
  output logic [4:0]  rd2_sel_o,
  output logic        rd3_en_o,
  output logic [4:0]  rd3_sel_o,
  output logic        wr_en_o,
  output logic [4:0]  wr_sel_o,
  output logic        crr1_en_o,
  output logic [2:0]  crr1_sel_o,
  output logic        crr2_en_o,
  output logic [2:0]  crr2_sel_o,
  output logic        crr3_en_o,
  output logic [2:0]  crr3_sel_o,
  output logic        crw_en_o,
  output logic [2:0]  crw_sel_o,
  output logic [1:0]  spr_rd_o,
  output logic        rc_o,
  output logic        lk_o,
  output logic        aa_o,
  output logic        upd_o,
  output logic [2:0]  len_o,
  output logic [4:0]  bo_o,
  output logic [4:0]  bi_o,
  output logic [4:0]  sh_o,
  output logic [4:0]  mb_o,
  output logic [4:0]  me_o,
  output logic [2:0]  bf_o
);

  logic [WORD_W-1:0] word;
  cls_e              cls;
  route_t            rt;

  pwr_byte_order #(.BYTES(WORD_W/8)) u_order (
    .raw_i  (insn_i),
    .keep_i (big_endian_i),
    .word_o (word)
  );

  pwr_class_table u_table (
    .word_i    (word),
    .cls_o     (cls),
    .illegal_o (illegal_o)
  );

  pwr_operand_route u_route (
    .cls_i  (cls),
    .prim_i (word[31:26]),
    .regf_i (word[25:11]),
    .lkaa_i (word[1:0]),
    .rt_o   (rt)
  );

  assign op_o       = rt.op;
  assign rd1_en_o   = rt.rd1_en;
  assign rd1_sel_o  = rt.rd1;
  assign rd2_en_o   = rt.rd2_en;
  assign rd2_sel_o  = rt.rd2;
  assign rd3_en_o   = rt.rd3_en;
  assign rd3_sel_o  = rt.rd3;
  assign wr_en_o    = rt.wr_en;
  assign wr_sel_o   = rt.wr;
  assign crr1_en_o  = rt.c1_en;
  assign crr1_sel_o = rt.c1;
  assign crr2_en_o  = rt.c2_en;
  assign crr2_sel_o = rt.c2;
  assign crr3_en_o  = rt.c3_en;
  assign crr3_sel_o = rt.c3;
  assign crw_en_o   = rt.cw_en;
  assign crw_sel_o  = rt.cw;
  assign spr_rd_o   = rt.spr;
  assign rc_o       = rt.rc;
  assign lk_o       = rt.lk;
  assign aa_o       = rt.aa;
  assign upd_o      = rt.upd;
  assign len_o      = rt.len;

  assign bo_o = word[25:21];
  assign bi_o = word[20:16];
  assign sh_o = word[15:11];
  assign mb_o = word[10:6];
  assign me_o = word[5:1];
  assign bf_o = word[25:23];

  always_comb begin
    if (!$isunknown({insn_i, big_endian_i})) begin
      // R10
      illegal_quiet_chk: assert (!illegal_o ||
        (op_o == OP_NONE && !wr_en_o && !rd1_en_o && !rd3_en_o && !crw_en_o && len_o == '0))
        else $error("illegal word left a port active");
      // R3
      store_nowrite_chk: assert (op_o != OP_STORE || (!wr_en_o && rd3_en_o))
        else $error("store wrote a register or lacks its source");
      // R3
      len_scope_chk: assert ((len_o != '0) == (op_o == OP_LOAD || op_o == OP_STORE))
        else $error("access length outside memory ops");
      // R7
      spr_branch_chk: assert (spr_rd_o == SPR_NONE || op_o == OP_BR)
        else $error("special register read outside a branch");
      // R8
      crlog_rmw_chk: assert (op_o != OP_CRLOG || (crw_en_o && crr3_en_o && crw_sel_o == crr3_sel_o))
        else $error("CR logic target not read and written");
      // R9
      nop_word_chk: assert (word != 32'h6000_0000 || (op_o == OP_NONE && !illegal_o && !wr_en_o))
        else $error("no-op word did not decode quietly");
    end
  end

endmodule

// File: tb/pwr_subset_decoder_tb.sv
module pwr_subset_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] insn = 32'h0;
  logic        be   = 1'b1;

  logic [3:0] op_o;
  logic illegal_o, rd1_en_o, rd2_en_o, rd3_en_o, wr_en_o;
  logic [4:0] rd1_sel_o, rd2_sel_o, rd3_sel_o, wr_sel_o;
  logic crr1_en_o, crr2_en_o, crr3_en_o, crw_en_o;
  logic [2:0] crr1_sel_o, crr2_sel_o, crr3_sel_o, crw_sel_o;
  logic [1:0] spr_rd_o;
  logic rc_o, lk_o, aa_o, upd_o;
  logic [2:0] len_o;
  logic [4:0] bo_o, bi_o, sh_o, mb_o, me_o;
  logic [2:0] bf_o;

  pwr_subset_decoder dut_i (
    .insn_i(insn), .big_endian_i(be), .op_o(op_o), .illegal_o(illegal_o),
    .rd1_en_o(rd1_en_o), .rd1_sel_o(rd1_sel_o), .rd2_en_o(rd2_en_o), .rd2_sel_o(rd2_sel_o),
    .rd3_en_o(rd3_en_o), .rd3_sel_o(rd3_sel_o), .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o),
    .crr1_en_o(crr1_en_o), .crr1_sel_o(crr1_sel_o), .crr2_en_o(crr2_en_o), .crr2_sel_o(crr2_sel_o),
    .crr3_en_o(crr3_en_o), .crr3_sel_o(crr3_sel_o), .crw_en_o(crw_en_o), .crw_sel_o(crw_sel_o),
    .spr_rd_o(spr_rd_o), .rc_o(rc_o), .lk_o(lk_o), .aa_o(aa_o), .upd_o(upd_o), .len_o(len_o),
    .bo_o(bo_o), .bi_o(bi_o), .sh_o(sh_o), .mb_o(mb_o), .me_o(me_o), .bf_o(bf_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // expected values from the requirements
  int x_op, x_ill, x_r1e, x_r1, x_r2e, x_r2, x_r3e, x_r3, x_we, x_w;
  int x_c1e, x_c1, x_c2e, x_c2, x_c3e, x_c3, x_cwe, x_cw;
  int x_spr, x_rc, x_lk, x_aa, x_up, x_len;

  task automatic clr_exp();
    x_op = 0; x_ill = 0; x_r1e = 0; x_r1 = 0; x_r2e = 0; x_r2 = 0; x_r3e = 0; x_r3 = 0;
    x_we = 0; x_w = 0; x_c1e = 0; x_c1 = 0; x_c2e = 0; x_c2 = 0; x_c3e = 0; x_c3 = 0;
    x_cwe = 0; x_cw = 0; x_spr = 0; x_rc = 0; x_lk = 0; x_aa = 0; x_up = 0; x_len = 0;
  endtask

  task automatic fld(input string req, input string nm, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s: actual %0d expected %0d (word %h be %0d)", req, nm, act, exp, insn, be);
      bad = 1;
    end
  endtask

  task automatic compare(input string req, input logic [31:0] w);
    bit bad = 0;
    n_chk++;
    fld(req, "op", op_o, x_op, bad);          fld(req, "illegal", illegal_o, x_ill, bad);
    fld(req, "rd1_en", rd1_en_o, x_r1e, bad); fld(req, "rd1", rd1_sel_o, x_r1, bad);
    fld(req, "rd2_en", rd2_en_o, x_r2e, bad); fld(req, "rd2", rd2_sel_o, x_r2, bad);
    fld(req, "rd3_en", rd3_en_o, x_r3e, bad); fld(req, "rd3", rd3_sel_o, x_r3, bad);
    fld(req, "wr_en", wr_en_o, x_we, bad);    fld(req, "wr", wr_sel_o, x_w, bad);
    fld(req, "crr1_en", crr1_en_o, x_c1e, bad); fld(req, "crr1", crr1_sel_o, x_c1, bad);
    fld(req, "crr2_en", crr2_en_o, x_c2e, bad); fld(req, "crr2", crr2_sel_o, x_c2, bad);
    fld(req, "crr3_en", crr3_en_o, x_c3e, bad); fld(req, "crr3", crr3_sel_o, x_c3, bad);
    fld(req, "crw_en", crw_en_o, x_cwe, bad);   fld(req, "crw", crw_sel_o, x_cw, bad);
    fld(req, "spr", spr_rd_o, x_spr, bad);   fld(req, "rc", rc_o, x_rc, bad);
    fld(req, "lk", lk_o, x_lk, bad);         fld(req, "aa", aa_o, x_aa, bad);
    fld(req, "upd", upd_o, x_up, bad);       fld(req, "len", len_o, x_len, bad);
    // R11 raw fields
    fld(req, "bo", bo_o, int'(w[25:21]), bad); fld(req, "bi", bi_o, int'(w[20:16]), bad);
    fld(req, "sh", sh_o, int'(w[15:11]), bad); fld(req, "mb", mb_o, int'(w[10:6]), bad);
    fld(req, "me", me_o, int'(w[5:1]), bad);   fld(req, "bf", bf_o, int'(w[25:23]), bad);
    if (bad) n_fail++;
  endtask

  // apply in canonical order, then the byte-reversed image with the flag cleared (R1)
  task automatic apply(input string req, input logic [31:0] w);
    @(posedge clk); #1;
    insn = w; be = 1'b1;
    @(negedge clk);
    compare(req, w);
    @(posedge clk); #1;
    insn = {w[7:0], w[15:8], w[23:16], w[31:24]}; be = 1'b0;
    @(negedge clk);
    compare({req, "/R1"}, w);
  endtask

  localparam int K_ADD = 0, K_AND = 1, K_OR = 2, K_LWZX = 3, K_STWX = 4, K_ADDI = 5,
                 K_ADDIS = 6, K_ORI = 7, K_ANDI = 8, K_LWZ = 9, K_LWZU = 10, K_LBZ = 11,
                 K_LHZ = 12, K_STW = 13, K_STWU = 14, K_STB = 15, K_STH = 16, K_CMP = 17,
                 K_RLWIMI = 18, K_RLWINM = 19, K_RLWNM = 20, K_B = 21, K_BC = 22,
                 K_BCLR = 23, K_BCCTR = 24, K_CRAND = 25, K_LAST = 25;

  task automatic gen(input int k, input logic [4:0] a, b, c, d, e, input logic dot);
    logic [31:0] w;
    logic [15:0] imm;
    string req;
    imm = {c, d, e, dot};
    clr_exp();
    w = '0;
    req = "R2";
    case (k)
      K_ADD:  begin w = {6'd31, a, b, c, 10'd266, dot}; x_op = 1; x_we = 1; x_w = a;
                x_r1e = 1; x_r1 = b; x_r2e = 1; x_r2 = c; x_rc = dot; req = "R2/R4"; end
      K_AND, K_OR: begin
                w = {6'd31, a, b, c, (k == K_AND) ? 10'd28 : 10'd444, dot};
                x_op = (k == K_AND) ? 2 : 3; x_we = 1; x_w = b; x_r3e = 1; x_r3 = a;
                x_r2e = 1; x_r2 = c; x_rc = dot; req = "R2/R4"; end
      K_LWZX: begin w = {6'd31, a, b, c, 10'd23, 1'b0}; x_op = 4; x_we = 1; x_w = a;
                x_r1e = 1; x_r1 = b; x_r2e = 1; x_r2 = c; x_len = 4; req = "R3"; end
      K_STWX: begin w = {6'd31, a, b, c, 10'd151, 1'b0}; x_op = 5; x_r3e = 1; x_r3 = a;
                x_r1e = 1; x_r1 = b; x_r2e = 1; x_r2 = c; x_len = 4; req = "R3"; end
      K_ADDI, K_ADDIS: begin w = {(k == K_ADDI) ? 6'd14 : 6'd15, a, b, imm};
                x_op = 1; x_we = 1; x_w = a; x_r1e = 1; x_r1 = b; end
      K_ORI:  begin w = {6'd24, a, b, imm[15:1], 1'b1}; x_op = 3; x_we = 1; x_w = b;
                x_r3e = 1; x_r3 = a; req = "R2/R9"; end
      K_ANDI: begin w = {6'd28, a, b, imm}; x_op = 2; x_we = 1; x_w = b;
                x_r3e = 1; x_r3 = a; x_rc = 1; req = "R2/R4"; end
      K_LWZ, K_LWZU, K_LBZ, K_LHZ: begin
                case (k)
                  K_LWZ:  begin w[31:26] = 6'd32; x_len = 4; end
                  K_LWZU: begin w[31:26] = 6'd33; x_len = 4; x_up = 1; end
                  K_LBZ:  begin w[31:26] = 6'd34; x_len = 1; end
                  default: begin w[31:26] = 6'd40; x_len = 2; end
                endcase
                w[25:0] = {a, b, imm}; x_op = 4; x_we = 1; x_w = a; x_r1e = 1; x_r1 = b;
                req = "R3"; end
      K_STW, K_STWU, K_STB, K_STH: begin
                case (k)
                  K_STW:  begin w[31:26] = 6'd36; x_len = 4; end
                  K_STWU: begin w[31:26] = 6'd37; x_len = 4; x_up = 1; end
                  K_STB:  begin w[31:26] = 6'd38; x_len = 1; end
                  default: begin w[31:26] = 6'd44; x_len = 2; end
                endcase
                w[25:0] = {a, b, imm}; x_op = 5; x_r3e = 1; x_r3 = a; x_r1e = 1; x_r1 = b;
                req = "R3"; end
      K_CMP:  begin w = {6'd31, a[4:2], 2'b00, b, c, 10'd0, 1'b0}; x_op = 6;
                x_r1e = 1; x_r1 = b; x_r2e = 1; x_r2 = c; x_cwe = 1; x_cw = a[4:2]; req = "R5"; end
      K_RLWIMI, K_RLWINM, K_RLWNM: begin
                w = {(k == K_RLWIMI) ? 6'd20 : (k == K_RLWINM) ? 6'd21 : 6'd23, a, b, c, d, e, dot};
                x_op = 7; x_r3e = 1; x_r3 = a; x_we = 1; x_w = b; x_rc = dot;
                if (k == K_RLWNM) begin x_r2e = 1; x_r2 = c; end
                req = "R6/R4"; end
      K_B:    begin w = {6'd18, a, b, c, d, e[3:0], e[4], dot}; x_op = 8;
                x_aa = e[4]; x_lk = dot; req = "R7"; end
      K_BC:   begin w = {6'd16, a, b, c, d, e[3:0], e[4], dot}; x_op = 8;
                x_aa = e[4]; x_lk = dot; x_c1e = 1; x_c1 = b[4:2]; req = "R7"; end
      K_BCLR, K_BCCTR: begin
                w = {6'd19, a, b, 3'b000, c[1:0], (k == K_BCLR) ? 10'd16 : 10'd528, dot};
                x_op = 8; x_lk = dot; x_spr = (k == K_BCLR) ? 1 : 2;
                x_c1e = 1; x_c1 = b[4:2]; req = "R7"; end
      default: begin w = {6'd19, a, b, c, 10'd257, 1'b0}; x_op = 9;
                x_c1e = 1; x_c1 = b[4:2]; x_c2e = 1; x_c2 = c[4:2];
                x_c3e = 1; x_c3 = a[4:2]; x_cwe = 1; x_cw = a[4:2]; req = "R8"; end
    endcase
    apply(req, w);
  endtask

  task automatic expect_illegal(input logic [31:0] w);
    clr_exp(); x_ill = 1;
    apply("R10", w);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // reset-time state: word 0 is primary 0, outside the subset (R10)
    @(negedge clk);
    clr_exp(); x_ill = 1;
    compare("R10", 32'h0);

    // R9: the no-op word and a neighbouring ori
    clr_exp();
    apply("R9", 32'h6000_0000);
    clr_exp(); x_op = 3; x_we = 1; x_w = 0; x_r3e = 1; x_r3 = 0;
    apply("R9", 32'h6000_0001);

    // R4: explicit record-bit pair on add
    gen(K_ADD, 5'd3, 5'd4, 5'd5, 5'd0, 5'd0, 1'b1);
    gen(K_ADD, 5'd3, 5'd4, 5'd5, 5'd0, 5'd0, 1'b0);

    // edge field values: all zeros and all ones
    for (int k = 0; k <= K_LAST; k++) begin
      gen(k, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0);
      gen(k, 5'd31, 5'd31, 5'd31, 5'd31, 5'd31, 1'b1);
    end
    // varied field patterns
    for (int it = 0; it < 4; it++) begin
      for (int k = 0; k <= K_LAST; k++) begin
        gen(k, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
      end
    end

    // R10: encodings outside the subset
    expect_illegal({6'd30, 26'h0123456});
    expect_illegal({6'd58, 26'h0000002});
    expect_illegal({6'd62, 26'h0000001});
    expect_illegal({6'd31, 5'd1, 5'd2, 5'd3, 10'd778, 1'b0});
    expect_illegal({6'd31, 5'd1, 5'd2, 5'd3, 10'd999, 1'b0});
    expect_illegal({6'd19, 5'd1, 5'd2, 5'd3, 10'd0, 1'b0});
    expect_illegal({6'd1, 26'h3ffffff});

    done = 1;
    summary();
  end

endmodule